// File: doc/BRIEF.md
# Character Glyph ROM Access Port

This block sits on a CPU's byte-wide I/O bus and gives software access to character font ROMs, in which each glyph row is 16 bits wide but the ROM itself is addressed a byte at a time. Software first loads a 16-bit glyph row index through two byte registers, one for the upper byte and one for the lower byte. It then reads one of two data offsets to get the left or the right byte of that row. The block turns the index into a byte address by doubling it and, for the right byte, adding one. It drives that address to an external synchronous ROM and returns the byte the ROM supplies.

A second ROM level can be built in. It has its own index latch, which is loaded by the same register writes, and it is read through its own pair of data offsets. Each level has a presence input. When a level is marked absent, writes leave its latch unchanged and its reads return 0xFF. The read path takes one cycle of latency: a read request is answered by a one-cycle valid pulse two clock edges after it is sampled.

Top module: `glyph_rom_port`

## Requirements
- R1: After reset, both index latches and both ROM address outputs are zero and the read-valid output is low.
- R2: A write to offset 0x20 loads the upper byte of the index, and a write to offset 0x21 loads the lower byte. The other byte is kept.
- R3: Offsets 0x2C and 0x2D load the upper and lower index bytes exactly as 0x20 and 0x21 do.
- R4: A read at offset 0x22 drives ROM address index×2 on level one at the edge that samples the read. The read-valid output is high for one cycle after the following edge, carrying the ROM byte present in the cycle between the two edges.
- R5: A read at offset 0x23 behaves like R4 but uses byte address index×2+1.
- R6: While level one is marked absent, index writes leave its latch unchanged, its ROM address output holds its value, and reads at 0x22 and 0x23 return 0xFF with the normal timing.
- R7: Every index write (0x20, 0x21, 0x2C, 0x2D) also updates the level-two latch when level two is present.
- R8: Reads at offsets 0x2E and 0x2F use the level-two latch and ROM with the same doubling rule: 0x2E gives index×2 and 0x2F gives index×2+1.
- R9: While level two is marked absent, its latch ignores index writes and reads at 0x2E and 0x2F return 0xFF.
- R10: Only reads at the four data offsets raise read-valid. Without a read request a ROM address output does not change. Writes to any other offset change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_rd_i | input | 1 | Read strobe for one cycle |
| bus_ofs_i | input | 6 | Register offset within the I/O page |
| bus_wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | One-cycle pulse marking read data |
| rd_data_o | output | 8 | Read data |
| rom1_present_i | input | 1 | Level-one ROM is connected |
| rom1_addr_o | output | 17 | Level-one ROM byte address, registered |
| rom1_data_i | input | 8 | Level-one ROM data, valid the cycle after the address |
| rom2_present_i | input | 1 | Level-two ROM is connected |
| rom2_addr_o | output | 17 | Level-two ROM byte address, registered |
| rom2_data_i | input | 8 | Level-two ROM data, valid the cycle after the address |

## Verification
An index latch that holds a wrong value shows up on the ROM address output at the first read after it goes wrong, and it shows up one edge later as a wrong data byte. A latch that was wrongly written while its ROM was absent stays hidden until the ROM is marked present again and read. The bench therefore switches presence at random between operations, so that such an error is exposed at the next read. A pipeline flag that drops or duplicates a request is visible within two edges as a missing or extra valid pulse.

// File: rtl/glyph_port_pkg.sv
package glyph_port_pkg;

  localparam int OFS_W  = 6;
  localparam int BYTE_W = 8;

  localparam logic [OFS_W-1:0] OFS_IDX_HI     = 6'h20;
  localparam logic [OFS_W-1:0] OFS_IDX_LO     = 6'h21;
  localparam logic [OFS_W-1:0] OFS_L1_LEFT    = 6'h22;
  localparam logic [OFS_W-1:0] OFS_L1_RIGHT   = 6'h23;
  localparam logic [OFS_W-1:0] OFS_IDX_HI_ALT = 6'h2C;
  localparam logic [OFS_W-1:0] OFS_IDX_LO_ALT = 6'h2D;
  localparam logic [OFS_W-1:0] OFS_L2_LEFT    = 6'h2E;
  localparam logic [OFS_W-1:0] OFS_L2_RIGHT   = 6'h2F;

  localparam logic [BYTE_W-1:0] ABSENT_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LVL1 = 2'd1,
    RD_LVL2 = 2'd2
  } rd_level_e;

  typedef struct packed {
    logic      load_hi;
    logic      load_lo;
    rd_level_e rd_level;
    logic      rd_right;
  } port_cmd_t;

endpackage

// File: rtl/glyph_port_decode.sv
module glyph_port_decode
  import glyph_port_pkg::*;
(
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OFS_W-1:0] ofs_i,
  output port_cmd_t        cmd_o
);

  always_comb begin
    cmd_o          = '0;
    cmd_o.rd_level = RD_NONE;
    if (wr_i) begin
      cmd_o.load_hi = (ofs_i == OFS_IDX_HI) || (ofs_i == OFS_IDX_HI_ALT);
      cmd_o.load_lo = (ofs_i == OFS_IDX_LO) || (ofs_i == OFS_IDX_LO_ALT);
    end
    if (rd_i) begin
      unique case (ofs_i)
        OFS_L1_LEFT:  begin cmd_o.rd_level = RD_LVL1; cmd_o.rd_right = 1'b0; end
        OFS_L1_RIGHT: begin cmd_o.rd_level = RD_LVL1; cmd_o.rd_right = 1'b1; end
        OFS_L2_LEFT:  begin cmd_o.rd_level = RD_LVL2; cmd_o.rd_right = 1'b0; end
        OFS_L2_RIGHT: begin cmd_o.rd_level = RD_LVL2; cmd_o.rd_right = 1'b1; end
        default:      begin cmd_o.rd_level = RD_NONE; cmd_o.rd_right = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/glyph_index_latch.sv
module glyph_index_latch #(
  parameter int IDX_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present_i,
  input  logic              load_hi_i,
  input  logic              load_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int LO_W = BYTE_W;
  localparam int HI_W = IDX_W - BYTE_W;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic            hi_en, lo_en;

  always_comb begin
    hi_en = present_i && load_hi_i;
    lo_en = present_i && load_lo_i;
    hi_d  = wdata_i[HI_W-1:0];
    lo_d  = wdata_i[LO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign idx_o = {hi_q, lo_q};

endmodule

// File: rtl/glyph_rd_stage.sv
module glyph_rd_stage #(
  parameter int IDX_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              right_i,
  input  logic              present_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic [IDX_W:0]    rom_addr_o,
  output logic              vld_o,
  output logic [BYTE_W-1:0] data_o
);

  import glyph_port_pkg::ABSENT_BYTE;

  logic [IDX_W:0]    addr_q, addr_d;
  logic              addr_en;
  logic              pend_q, pend_d;
  logic              pres_q, pres_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    addr_en = req_i && present_i;
    addr_d  = {idx_i, right_i};
    pend_d  = req_i;
    pres_d  = req_i && present_i;
    vld_d   = pend_q;
    data_en = pend_q;
    data_d  = pres_q ? rom_data_i : ABSENT_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pend_q <= 1'b0;
      pres_q <= 1'b0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      pend_q <= pend_d;
      pres_q <= pres_d;
      vld_q  <= vld_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign rom_addr_o = addr_q;
  assign vld_o      = vld_q;
  assign data_o     = data_q;

endmodule

// File: rtl/glyph_rom_port.sv
module glyph_rom_port
  import glyph_port_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter bit HAS_LEVEL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [5:0]        bus_ofs_i,
  input  logic [7:0]        bus_wdata_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  input  logic              rom1_present_i,
  output logic [IDX_W:0]    rom1_addr_o,
  input  logic [7:0]        rom1_data_i,
  input  logic              rom2_present_i,
  output logic [IDX_W:0]    rom2_addr_o,
  input  logic [7:0]        rom2_data_i
);

  localparam int NLVL = 2;

  port_cmd_t         cmd;
  logic              lvl_present [NLVL];
  logic [IDX_W-1:0]  lvl_idx     [NLVL];
  logic              lvl_req     [NLVL];
  logic [IDX_W:0]    lvl_addr    [NLVL];
  logic              lvl_vld     [NLVL];
  logic [BYTE_W-1:0] lvl_data    [NLVL];
  logic [BYTE_W-1:0] lvl_rom     [NLVL];

  glyph_port_decode u_decode (
    .wr_i  (bus_wr_i),
    .rd_i  (bus_rd_i),
    .ofs_i (bus_ofs_i),
    .cmd_o (cmd)
  );

  assign lvl_present[0] = rom1_present_i;
  assign lvl_rom[0]     = rom1_data_i;
  assign lvl_rom[1]     = rom2_data_i;

  generate
    if (HAS_LEVEL2) begin : g_l2_built
      assign lvl_present[1] = rom2_present_i;
    end else begin : g_l2_absent
      assign lvl_present[1] = 1'b0;
    end
  endgenerate

  assign lvl_req[0] = (cmd.rd_level == RD_LVL1);
  assign lvl_req[1] = (cmd.rd_level == RD_LVL2);

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    glyph_index_latch #(
      .IDX_W  (IDX_W),
      .BYTE_W (BYTE_W)
    ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .present_i (lvl_present[g]),
      .load_hi_i (cmd.load_hi),
      .load_lo_i (cmd.load_lo),
      .wdata_i   (bus_wdata_i),
      .idx_o     (lvl_idx[g])
    );

    glyph_rd_stage #(
      .IDX_W  (IDX_W),
      .BYTE_W (BYTE_W)
    ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (lvl_req[g]),
      .right_i    (cmd.rd_right),
      .present_i  (lvl_present[g]),
      .idx_i      (lvl_idx[g]),
      .rom_data_i (lvl_rom[g]),
      .rom_addr_o (lvl_addr[g]),
      .vld_o      (lvl_vld[g]),
      .data_o     (lvl_data[g])
    );
  end

  assign rom1_addr_o = lvl_addr[0];
  assign rom2_addr_o = lvl_addr[1];

  always_comb begin
    rd_valid_o = lvl_vld[0] || lvl_vld[1];
    rd_data_o  = lvl_vld[1] ? lvl_data[1] : lvl_data[0];
  end

endmodule

// File: rtl/glyph_port_chk.sv
module glyph_port_chk #(
  parameter int IDX_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr_i,
  input logic           bus_rd_i,
  input logic [5:0]     bus_ofs_i,
  input logic [7:0]     bus_wdata_i,
  input logic           rd_valid_o,
  input logic [7:0]     rd_data_o,
  input logic           rom1_present_i,
  input logic [IDX_W:0] rom1_addr_o,
  input logic [7:0]     rom1_data_i,
  input logic           rom2_present_i,
  input logic [IDX_W:0] rom2_addr_o,
  input logic [7:0]     rom2_data_i
);

  logic data_rd, l1_left, l1_right, l1_ok, l1_abs;
  assign data_rd  = bus_rd_i && (bus_ofs_i inside {6'h22, 6'h23, 6'h2E, 6'h2F});
  assign l1_left  = bus_rd_i && rom1_present_i && (bus_ofs_i == 6'h22);
  assign l1_right = bus_rd_i && rom1_present_i && (bus_ofs_i == 6'h23);
  assign l1_ok    = l1_left || l1_right;
  assign l1_abs   = bus_rd_i && !rom1_present_i && (bus_ofs_i inside {6'h22, 6'h23});

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(data_rd, 2)); // R10
  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> ##2 rd_valid_o); // R4
  AST_LEFT_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    l1_left |=> (rom1_addr_o[0] == 1'b0)); // R4
  AST_RIGHT_ODD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    l1_right |=> (rom1_addr_o[0] == 1'b1)); // R5
  AST_L1_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && $past(l1_ok, 2)) |-> (rd_data_o == $past(rom1_data_i))); // R4
  AST_L1_ABSENT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    l1_abs |-> ##2 (rd_data_o == 8'hFF)); // R6
  AST_ADDR1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(rom1_addr_o)); // R10
  AST_ADDR2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(rom2_addr_o)); // R10

endmodule

bind glyph_rom_port glyph_port_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/glyph_rom_port_tb.sv
module glyph_rom_port_tb;

  localparam int IDX_W = 16;

  logic           clk;
  logic           rst_n;
  logic           bus_wr, bus_rd;
  logic [5:0]     bus_ofs;
  logic [7:0]     bus_wdata;
  logic           rd_valid;
  logic [7:0]     rd_data;
  logic           r1_pres, r2_pres;
  logic [IDX_W:0] r1_addr, r2_addr;
  logic [7:0]     r1_data, r2_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] exp1, exp2;

  glyph_rom_port #(.IDX_W(IDX_W), .HAS_LEVEL2(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_ofs_i(bus_ofs), .bus_wdata_i(bus_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rom1_present_i(r1_pres), .rom1_addr_o(r1_addr), .rom1_data_i(r1_data),
    .rom2_present_i(r2_pres), .rom2_addr_o(r2_addr), .rom2_data_i(r2_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] rom1_fn(input logic [IDX_W:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] rom2_fn(input logic [IDX_W:0] a);
    return (a[7:0] + a[16:9]) ^ 8'hC3;
  endfunction

  assign r1_data = rom1_fn(r1_addr);
  assign r2_data = rom2_fn(r2_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (ofs inside {6'h20, 6'h2C}) begin
      if (r1_pres) exp1[15:8] = d;
      if (r2_pres) exp2[15:8] = d;
    end else if (ofs inside {6'h21, 6'h2D}) begin
      if (r1_pres) exp1[7:0] = d;
      if (r2_pres) exp2[7:0] = d;
    end
  endtask

  task automatic do_read(input logic [5:0] ofs, input string req);
    logic        lvl2, right, pres;
    logic [15:0] idx;
    logic [IDX_W:0] a_before;
    lvl2  = (ofs == 6'h2E) || (ofs == 6'h2F);
    right = ofs[0];
    pres  = lvl2 ? r2_pres : r1_pres;
    idx   = lvl2 ? exp2 : exp1;
    a_before = lvl2 ? r2_addr : r1_addr;
    @(negedge clk);
    bus_rd = 1'b1; bus_ofs = ofs;
    @(negedge clk);
    bus_rd = 1'b0;
    check({req, " valid low before data"}, rd_valid, 1'b0);
    if (pres)
      check({req, " rom address"}, lvl2 ? r2_addr : r1_addr, {idx, right});
    else
      check({req, " address held while absent"}, lvl2 ? r2_addr : r1_addr, a_before);
    @(negedge clk);
    check({req, " valid pulse"}, rd_valid, 1'b1);
    if (!pres)      check({req, " absent data"}, rd_data, 8'hFF);
    else if (lvl2)  check({req, " data"}, rd_data, rom2_fn({idx, right}));
    else            check({req, " data"}, rd_data, rom1_fn({idx, right}));
    @(negedge clk);
    check({req, " valid is one cycle"}, rd_valid, 1'b0);
  endtask

  task automatic read_any(input logic [5:0] ofs);
    case (ofs)
      6'h22: do_read(ofs, "R4");
      6'h23: do_read(ofs, "R5");
      6'h2E: do_read(ofs, "R8");
      default: do_read(ofs, "R8");
    endcase
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] seed;
    seed = 32'd20250117;
    void'($urandom(seed));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_ofs = '0; bus_wdata = '0;
    r1_pres = 1'b1; r2_pres = 1'b1;
    exp1 = '0; exp2 = '0;
    repeat (3) @(negedge clk);
    check("R1 valid after reset", rd_valid, 1'b0);
    check("R1 rom1 address after reset", r1_addr, '0);
    check("R1 rom2 address after reset", r2_addr, '0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(6'h22, "R1 cleared latch1");
    do_read(6'h2F, "R1 cleared latch2");

    do_write(6'h20, 8'hA5);
    do_write(6'h21, 8'h3C);
    do_read(6'h22, "R2 left");
    do_read(6'h23, "R5 right");
    do_write(6'h2C, 8'h12);
    do_read(6'h23, "R3 alias hi");
    do_write(6'h2D, 8'hFE);
    do_read(6'h22, "R3 alias lo");
    do_read(6'h2E, "R7 level2 shares writes");
    do_read(6'h2F, "R8 level2 right");

    do_write(6'h22, 8'h00);
    do_write(6'h1F, 8'h77);
    do_write(6'h2A, 8'h66);
    do_read(6'h22, "R10 stray writes ignored");
    @(negedge clk);
    bus_rd = 1'b1; bus_ofs = 6'h24;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    check("R10 no valid for non-data read", rd_valid, 1'b0);

    r1_pres = 1'b0;
    do_write(6'h20, 8'h99);
    do_write(6'h21, 8'h88);
    do_read(6'h22, "R6 absent left");
    do_read(6'h23, "R6 absent right");
    do_read(6'h2E, "R7 level2 updated while level1 absent");
    r1_pres = 1'b1;
    do_read(6'h23, "R6 latch kept while absent");

    r2_pres = 1'b0;
    do_write(6'h2C, 8'h01);
    do_read(6'h2F, "R9 absent level2");
    r2_pres = 1'b1;
    do_read(6'h2E, "R9 latch2 kept while absent");
    do_write(6'h20, 8'hFF);
    do_write(6'h21, 8'hFF);
    do_read(6'h23, "R5 top address");
    do_read(6'h2F, "R8 top address");

    for (int i = 0; i < 300; i++) begin
      int op;
      logic [5:0] ofs;
      op = $urandom_range(0, 9);
      if (op == 0) begin
        r1_pres = ($urandom_range(0, 3) != 0);
        r2_pres = ($urandom_range(0, 3) != 0);
      end else if (op < 5) begin
        case ($urandom_range(0, 3))
          0: ofs = 6'h20;
          1: ofs = 6'h21;
          2: ofs = 6'h2C;
          default: ofs = 6'h2D;
        endcase
        do_write(ofs, 8'($urandom));
      end else begin
        case ($urandom_range(0, 3))
          0: ofs = 6'h22;
          1: ofs = 6'h23;
          2: ofs = 6'h2E;
          default: ofs = 6'h2F;
        endcase
        read_any(ofs);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule